// File: doc/BRIEF.md
# Cascadable Four-Channel Timer Bank

The block holds four 16-bit up-counters. Each counter has its own reload value and its own control byte, and all of them are reached through one synchronous register port. A channel either counts a divided version of the core clock or, from channel 1 upward, counts the overflows of the channel below it. Chaining channels this way builds wider or slower counters.

Every overflow reloads the counter from its reload value and raises a strobe that the next channel can count. If the channel's interrupt bit is set, the overflow also raises a one-cycle interrupt request. Software writes a reload value and a control byte, and it can read back the live count of any channel at any time.

A write takes effect at the rising clock edge where `wr_en` is high. `addr_hi` low selects the reload value on a write and the live count on a read. `addr_hi` high selects the control byte. Reads are combinational from the current address.

Top module: `cascade_timer_bank`

## Requirements
- R1: Control bits [1:0] select the count rate while the channel is enabled and not chained. 0 advances the count every cycle, 1 every 64 cycles, 2 every 256 cycles and 3 every 1024 cycles. The first advance comes that many cycles after the edge that enabled the channel.
- R2: A control write keeps only bits 7, 6, 2, 1 and 0 of the data (mask 0x00C7). A control read returns the stored byte with all other bits zero.
- R3: An advance from 0xFFFF loads the reload value instead of counting on. In that cycle `ovf` for the channel is high, so one period is (0x10000 − reload) advances.
- R4: The edge at which control bit 7 (enable) changes from 0 to 1 loads the counter with the stored reload value.
- R5: A reload write stores the value only. The count keeps its own progress until the next overflow or the next enable edge, and that event then uses the new value.
- R6: When control bit 2 (chain) is set on channel n ≥ 1, the channel advances by one in the cycle that channel n−1 overflows and never on the divided clock. Its own wrap reloads it, pulses its `ovf` in the same cycle as the lower channel's, and raises its interrupt.
- R7: Channel 0 counts the divided clock even when its chain bit is set, and the stored bit still reads back.
- R8: Clearing the enable bit freezes the count. The frozen value stays readable and does not change while the channel stays disabled.
- R9: In the cycle after an overflow of a channel with control bit 6 set, `irq` for that channel is high for one cycle. With bit 6 clear, the overflow raises no interrupt.
- R10: A chained channel with its enable bit clear ignores overflows of the channel below it.
- R11: Changing bits [1:0] of a running channel keeps the current count and restarts the rate divider. The first advance under the new rate comes a full divided period after the write edge.
- R12: After reset every count, reload value and control byte is zero, and `irq` and `ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| addr_ch | input | 2 | Channel index for read and write |
| addr_hi | input | 1 | 0 selects reload (write) or live count (read); 1 selects the control byte |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the addressed register |
| irq | output | 4 | One-cycle interrupt request per channel, registered |
| ovf | output | 4 | Overflow strobe per channel, high in the cycle the count wraps |

## Verification
The assertions check four things on every cycle:
- A control read never shows a bit outside the kept mask.
- Every interrupt pulse follows an overflow of the same channel.
- A chained channel advances only while the channel below it overflows.
- The count of a disabled channel that is left alone stays still.

Only the bench scenarios can show the following, because they need cycle counts or stored values that the ports do not expose:
- The exact cycle of each divided advance, and the divider restart after a rate change.
- The reload value loaded on wrap and on an enable edge.
- The deferred effect of a reload write.
- The channel-0 exception to chaining.

// File: rtl/cascade_timer_bank.sv
module cascade_timer_bank #(
  parameter int CHANNELS = 4,
  parameter int WIDTH    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(CHANNELS)-1:0] addr_ch,
  input  logic                        addr_hi,
  input  logic [WIDTH-1:0]            wr_data,
  output logic [WIDTH-1:0]            rd_data,
  output logic [CHANNELS-1:0]         irq,
  output logic [CHANNELS-1:0]         ovf
);

  localparam int IDX_W = $clog2(CHANNELS);
  localparam int DIV_W = 10;
  localparam logic [7:0] CTL_MASK = 8'hC7;

  logic [WIDTH-1:0]    cnt_w [CHANNELS];
  logic [7:0]          ctl_w [CHANNELS];
  logic [CHANNELS-1:0] en_v;
  logic [CHANNELS-1:0] casc_v;
  logic [CHANNELS-1:0] step_v;
  logic [CHANNELS-1:0] chain_in;

  assign chain_in = {ovf[CHANNELS-2:0], 1'b0};

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] rld_q;
    logic [7:0]       ctl_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;
    logic             irq_q;
    logic             hit, ctl_wr, rld_wr, start, rate_chg, tick;
    logic [7:0]       new_ctl;

    assign hit      = wr_en && (addr_ch == IDX_W'(g));
    assign ctl_wr   = hit && addr_hi;
    assign rld_wr   = hit && !addr_hi;
    assign new_ctl  = wr_data[7:0] & CTL_MASK;
    assign start    = ctl_wr && new_ctl[7] && !ctl_q[7];
    assign rate_chg = ctl_wr && (new_ctl[1:0] != ctl_q[1:0]);

    assign en_v[g]   = ctl_q[7];
    assign casc_v[g] = (g != 0) && ctl_q[2];

    always_comb begin
      case (ctl_q[1:0])
        2'd0:    mask = '0;
        2'd1:    mask = DIV_W'(63);
        2'd2:    mask = DIV_W'(255);
        default: mask = '1;
      endcase
    end

    assign tick      = en_v[g] && !casc_v[g] && ((div_q & mask) == mask);
    assign step_v[g] = casc_v[g] ? (en_v[g] && chain_in[g]) : tick;
    assign ovf[g]    = step_v[g] && (&cnt_q);
    assign irq[g]    = irq_q;
    assign cnt_w[g]  = cnt_q;
    assign ctl_w[g]  = ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        rld_q <= '0;
        ctl_q <= '0;
        div_q <= '0;
        irq_q <= 1'b0;
      end else begin
        irq_q <= ovf[g] && ctl_q[6];
        if (rld_wr) rld_q <= wr_data;
        if (ctl_wr) ctl_q <= new_ctl;
        if (start)       cnt_q <= rld_q;
        else if (ovf[g]) cnt_q <= rld_q;
        else if (step_v[g]) cnt_q <= cnt_q + 1'b1;
        if (start || rate_chg)           div_q <= '0;
        else if (en_v[g] && !casc_v[g])  div_q <= div_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (addr_hi) rd_data = WIDTH'(ctl_w[addr_ch]);
    else         rd_data = cnt_w[addr_ch];
  end

endmodule

// File: rtl/cascade_timer_bank_checker.sv
module cascade_timer_bank_checker #(
  parameter int CHANNELS = 4,
  parameter int WIDTH    = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [$clog2(CHANNELS)-1:0] addr_ch,
  input logic                        addr_hi,
  input logic [WIDTH-1:0]            rd_data,
  input logic [CHANNELS-1:0]         irq,
  input logic [CHANNELS-1:0]         ovf,
  input logic [CHANNELS-1:0]         en_v,
  input logic [CHANNELS-1:0]         casc_v,
  input logic [CHANNELS-1:0]         step_v
);
  localparam int IDX_W = $clog2(CHANNELS);

  AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hi |-> ((rd_data & ~WIDTH'(16'h00C7)) == '0)); // R2

  for (genvar i = 0; i < CHANNELS; i++) begin : g_chk
    AST_IRQ_AFTER_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> $past(ovf[i])); // R9

    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_hi && addr_ch == IDX_W'(i) &&
       $past(!addr_hi && addr_ch == IDX_W'(i) && !en_v[i] && !wr_en))
      |-> $stable(rd_data)); // R8

    if (i > 0) begin : g_casc
      AST_CHAIN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (casc_v[i] && step_v[i]) |-> ovf[i-1]); // R6
    end
  end
endmodule

bind cascade_timer_bank cascade_timer_bank_checker #(.CHANNELS(CHANNELS), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_ch(addr_ch), .addr_hi(addr_hi),
  .rd_data(rd_data), .irq(irq), .ovf(ovf), .en_v(en_v), .casc_v(casc_v), .step_v(step_v)
);

// File: tb/cascade_timer_bank_tb.sv
module cascade_timer_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr_ch = '0;
  logic        addr_hi = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [3:0]  irq, ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cascade_timer_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_ch(addr_ch), .addr_hi(addr_hi),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .ovf(ovf)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int ch, input bit hi, input logic [15:0] d);
    addr_ch = 2'(ch); addr_hi = hi; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input bit hi, output logic [15:0] v);
    addr_ch = 2'(ch); addr_hi = hi;
    #1 v = rd_data;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [15:0] v;
    do_reset();
    for (int c = 0; c < 4; c++) begin
      rd(c, 0, v); check("R12 count", v, 16'h0);
      rd(c, 1, v); check("R12 control", v, 16'h0);
    end
    check("R12 irq", {12'h0, irq}, 16'h0);
    check("R12 ovf", {12'h0, ovf}, 16'h0);
  endtask

  task automatic t_rates();
    logic [15:0] v;
    for (int m = 0; m < 4; m++) begin
      int per = (m == 0) ? 1 : (1 << (4 + 2 * m));
      do_reset();
      wr(3, 0, 16'h0200);
      wr(3, 1, 16'(16'h80 | m));
      if (m == 0) begin
        wait_cyc(3); rd(3, 0, v); check("R1 rate0", v, 16'h0203);
      end else begin
        wait_cyc(per - 1); rd(3, 0, v); check("R1 before tick", v, 16'h0200);
        wait_cyc(1);       rd(3, 0, v); check("R1 at tick", v, 16'h0201);
      end
    end
  endtask

  task automatic t_ctrl_mask();
    logic [15:0] v;
    do_reset();
    wr(2, 1, 16'hFFFF);
    rd(2, 1, v); check("R2 mask", v, 16'h00C7);
  endtask

  task automatic t_overflow_irq();
    logic [15:0] v;
    do_reset();
    wr(0, 0, 16'hFFF0);
    wr(0, 1, 16'h00C0);
    rd(0, 0, v); check("R4 load on enable", v, 16'hFFF0);
    wait_cyc(15);
    rd(0, 0, v); check("R3 at max", v, 16'hFFFF);
    check("R3 ovf strobe", {15'h0, ovf[0]}, 16'h1);
    check("R9 no irq yet", {15'h0, irq[0]}, 16'h0);
    wait_cyc(1);
    rd(0, 0, v); check("R3 reload", v, 16'hFFF0);
    check("R9 irq pulse", {15'h0, irq[0]}, 16'h1);
    wait_cyc(1);
    rd(0, 0, v); check("R3 next", v, 16'hFFF1);
    check("R9 irq one cycle", {15'h0, irq[0]}, 16'h0);
  endtask

  task automatic t_reload_write();
    logic [15:0] v;
    do_reset();
    wr(0, 0, 16'h0010);
    wr(0, 1, 16'h0080);
    rd(0, 0, v); check("R4 enable load", v, 16'h0010);
    wr(0, 0, 16'h8000);
    rd(0, 0, v); check("R5 reload write deferred", v, 16'h0011);
    wr(0, 1, 16'h0000);
    rd(0, 0, v); check("R8 frozen value", v, 16'h0012);
    wr(0, 1, 16'h0080);
    rd(0, 0, v); check("R5 new reload on enable", v, 16'h8000);
  endtask

  task automatic t_freeze();
    logic [15:0] v;
    do_reset();
    wr(1, 1, 16'h0080);
    wait_cyc(9);
    rd(1, 0, v); check("R8 running", v, 16'h0009);
    wr(1, 1, 16'h0000);
    wait_cyc(5);
    rd(1, 0, v); check("R8 frozen", v, 16'h000A);
  endtask

  task automatic t_cascade();
    logic [15:0] v;
    do_reset();
    wr(1, 0, 16'hFFFE);
    wr(1, 1, 16'h00C4);
    wr(0, 0, 16'hFFFE);
    wr(0, 1, 16'h0080);
    wait_cyc(1);
    rd(1, 0, v); check("R6 no divided advance", v, 16'hFFFE);
    wait_cyc(1);
    rd(1, 0, v); check("R6 counts lower overflow", v, 16'hFFFF);
    check("R9 no irq when bit6 clear", {15'h0, irq[0]}, 16'h0);
    wait_cyc(1);
    check("R6 both overflow", {14'h0, ovf[1:0]}, 16'h0003);
    wait_cyc(1);
    rd(1, 0, v); check("R6 chained reload", v, 16'hFFFE);
    check("R6 chained irq", {15'h0, irq[1]}, 16'h1);
  endtask

  task automatic t_disabled_chain();
    logic [15:0] v;
    do_reset();
    wr(0, 0, 16'hFFFF);
    wr(0, 1, 16'h0080);
    wr(1, 0, 16'h0005);
    wr(1, 1, 16'h0004);
    wait_cyc(10);
    rd(1, 0, v); check("R10 disabled chain ignores", v, 16'h0000);
    wr(1, 1, 16'h0084);
    wait_cyc(3);
    rd(1, 0, v); check("R6 chain per overflow", v, 16'h0008);
  endtask

  task automatic t_ch0_chain_bit();
    logic [15:0] v;
    do_reset();
    wr(0, 0, 16'h0100);
    wr(0, 1, 16'h0084);
    rd(0, 1, v); check("R7 bit kept", v, 16'h0084);
    wait_cyc(5);
    rd(0, 0, v); check("R7 channel0 counts clock", v, 16'h0105);
  endtask

  task automatic t_rate_change();
    logic [15:0] v;
    do_reset();
    wr(0, 1, 16'h0081);
    wait_cyc(100);
    rd(0, 0, v); check("R1 divided count", v, 16'h0001);
    wr(0, 1, 16'h0080);
    rd(0, 0, v); check("R11 count kept", v, 16'h0001);
    wait_cyc(5);
    rd(0, 0, v); check("R11 new rate", v, 16'h0006);
    wr(0, 1, 16'h0081);
    wait_cyc(63);
    rd(0, 0, v); check("R11 divider restarted", v, 16'h0007);
    wait_cyc(1);
    rd(0, 0, v); check("R11 first tick", v, 16'h0008);
  endtask

  initial begin
    t_reset_state();
    t_rates();
    t_ctrl_mask();
    t_overflow_irq();
    t_reload_write();
    t_freeze();
    t_cascade();
    t_disabled_chain();
    t_ch0_chain_bit();
    t_rate_change();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule